// File: doc/BRIEF.md
# Synchronized Phase Load Controller

This block sits between a parallel host bus and nine oscillator channels. Channel 0 is the reference, and channels 1 to 8 carry phase offsets. In synchronous mode the host places one 48-bit frequency word and one 14-bit phase word on the bus. It then pulls a channel's active-low load strobe. The falling edge starts a timed load that copies both words into that channel's pending registers. Once every channel is staged, the host pulls the common commit strobe low, and all nine channels move their pending values into their active registers on the same clock edge.

The frequency word is scaled at 1 µHz per LSB and is not range-checked. A phase value N stands for an offset of N·360°/16384. The reference channel is loaded first, with phase 0. BUSY stays low during the per-channel loads. It is raised only by an accepted commit, for the apply time. Toggling the mode input in either direction runs a reset sequence that sets every channel back to the 10 MHz default with zero phase. Mistimed strobes are dropped, and the drop is recorded in sticky error flags.

Top module: `sync_phase_loader`

## Requirements
- R1: After reset, every active frequency equals the default word 10,000,000,000,000 (10 MHz), every active phase is 0, and busy, ld_err and commit_err are all 0.
- R2: A falling edge on ld_n[c] captures freq_word and phase_word into channel c's pending registers. Bit 0 is the reference channel and bits 1 to 8 are the offset channels. Active outputs do not change until a commit.
- R3: busy stays 0 for the whole of every per-channel load.
- R4: An accepted falling edge on commit_n copies all nine pending pairs into the active outputs on one clock edge, three rising edges after the strobe is driven low. busy rises on that same edge and stays 1 for exactly APPLY_CYC = 34 cycles (170 ns at 5 ns).
- R5: A channel load lasts LOAD_CYC = 86 cycles. A further strobe on that channel during the load is ignored, so the first captured values are kept, and ld_err[c] is set and held.
- R6: A commit that falls while any load is running, within SETUP_CYC = 5 cycles after the last load ends, or while busy, is ignored: outputs stay unchanged, busy stays 0, and commit_err is set and held.
- R7: A change of mode_sync in either direction returns every pending and active frequency to the default and every phase to 0, and clears ld_err and commit_err.
- R8: While mode_sync is 0 (independent mode), channel strobes and the commit strobe have no effect.
- R9: Frequency words pass through without range checking; the value 48'hFFFF_FFFF_FFFF reaches the active output unchanged.
- R10: A load on one channel leaves every other channel's pending values untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sync | input | 1 | 1 = synchronous mode, 0 = independent mode |
| freq_word | input | 48 | Shared frequency word, 1 µHz per LSB |
| phase_word | input | 14 | Phase word, 360°/16384 per LSB |
| ld_n | input | 9 | Active-low per-channel load strobes; bit 0 is the reference |
| commit_n | input | 1 | Active-low common commit strobe |
| busy | output | 1 | High during the apply sequence that follows an accepted commit |
| act_freq | output | 432 | Active frequencies, channel c at bits [48c+47:48c] |
| act_phase | output | 126 | Active phases, channel c at bits [14c+13:14c] |
| ld_err | output | 9 | Sticky flag per channel for a strobe dropped during a load |
| commit_err | output | 1 | Sticky flag for a dropped commit |

## Verification
Every strobe passes through a two-flop synchronizer and an edge register, so a change driven between edges acts on the third rising edge that follows. The active outputs and busy are checked 1 ns after that edge. The busy pulse is then counted edge by edge and must last exactly 34 cycles. Loads are allowed 100 cycles, which covers the 86-cycle load and the 5-cycle setup margin. busy is sampled on every one of those cycles. Mode changes are checked 8 cycles after the edge that drives them.

// File: rtl/pload_pkg.sv
package pload_pkg;
  // Converts a duration in ns to a whole number of clock cycles, rounding up.
  function automatic int ns_to_cyc(input int dur_ns, input int clk_ns);
    return (dur_ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int   W    = 1,
  parameter logic INIT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= {W{INIT}};
      s2 <= {W{INIT}};
      s3 <= {W{INIT}};
    end else begin
      s1 <= in_raw;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign prev = s3;
endmodule

// File: rtl/chan_loader.sv
module chan_loader #(
  parameter int             FW       = 48,
  parameter int             PW       = 14,
  parameter int             LOAD_CYC = 86,
  parameter logic [FW-1:0]  DEF_FREQ = 48'd10_000_000_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          go,
  input  logic [FW-1:0] freq_in,
  input  logic [PW-1:0] phase_in,
  output logic [FW-1:0] pend_freq,
  output logic [PW-1:0] pend_phase,
  output logic          loading,
  output logic          err
);
  localparam int CW = $clog2(LOAD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOAD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_freq  <= DEF_FREQ;
      pend_phase <= '0;
      loading    <= 1'b0;
      cnt        <= '0;
      err        <= 1'b0;
    end else if (clr) begin
      pend_freq  <= DEF_FREQ;
      pend_phase <= '0;
      loading    <= 1'b0;
      cnt        <= '0;
      err        <= 1'b0;
    end else begin
      if (loading) begin
        if (cnt == '0) loading <= 1'b0;
        else           cnt     <= cnt - 1'b1;
      end
      if (go && en) begin
        if (loading) begin
          err <= 1'b1;
        end else begin
          pend_freq  <= freq_in;
          pend_phase <= phase_in;
          loading    <= 1'b1;
          cnt        <= LAST;
        end
      end
    end
  end

  p_drop_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && en && loading && !clr) |=> (err && $stable(pend_freq) && $stable(pend_phase)));

  p_load_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loading) |-> ($past(cnt) == '0 || $past(clr)));
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl #(
  parameter int APPLY_CYC = 34,
  parameter int SETUP_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic go,
  input  logic any_loading,
  output logic commit_go,
  output logic busy,
  output logic err
);
  localparam int AW = $clog2(APPLY_CYC + 1);
  localparam int IW = $clog2(SETUP_CYC + 1);
  localparam logic [AW-1:0] A_LAST = AW'(APPLY_CYC - 1);
  localparam logic [IW-1:0] I_FULL = IW'(SETUP_CYC);

  logic [AW-1:0] a_cnt;
  logic [IW-1:0] idle_cnt;
  logic          ready;

  assign ready     = !any_loading && (idle_cnt == I_FULL) && !busy;
  assign commit_go = go && en && ready && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      a_cnt    <= '0;
      idle_cnt <= I_FULL;
      err      <= 1'b0;
    end else if (clr) begin
      busy     <= 1'b0;
      a_cnt    <= '0;
      idle_cnt <= I_FULL;
      err      <= 1'b0;
    end else begin
      if (any_loading)             idle_cnt <= '0;
      else if (idle_cnt != I_FULL) idle_cnt <= idle_cnt + 1'b1;
      if (busy) begin
        if (a_cnt == '0) busy  <= 1'b0;
        else             a_cnt <= a_cnt - 1'b1;
      end
      if (go && en) begin
        if (ready) begin
          busy  <= 1'b1;
          a_cnt <= A_LAST;
        end else begin
          err <= 1'b1;
        end
      end
    end
  end

  p_commit_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && en && any_loading && !clr) |=> (err && !$rose(busy)));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && a_cnt != '0 && !clr) |=> busy);
endmodule

// File: rtl/sync_phase_loader.sv
module sync_phase_loader #(
  parameter int            NCH      = 9,
  parameter int            FW       = 48,
  parameter int            PW       = 14,
  parameter int            CLK_NS   = 5,
  parameter int            LOAD_NS  = 430,
  parameter int            APPLY_NS = 170,
  parameter int            SETUP_NS = 25,
  parameter logic [FW-1:0] DEF_FREQ = 48'd10_000_000_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic [FW-1:0]     freq_word,
  input  logic [PW-1:0]     phase_word,
  input  logic [NCH-1:0]    ld_n,
  input  logic              commit_n,
  output logic              busy,
  output logic [NCH*FW-1:0] act_freq,
  output logic [NCH*PW-1:0] act_phase,
  output logic [NCH-1:0]    ld_err,
  output logic              commit_err
);
  import pload_pkg::*;

  localparam int LOAD_CYC  = ns_to_cyc(LOAD_NS, CLK_NS);
  localparam int APPLY_CYC = ns_to_cyc(APPLY_NS, CLK_NS);
  localparam int SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS);
  localparam int SW        = NCH + 1;

  // Strobe synchronizers: bits [NCH-1:0] are the channels, bit NCH is commit.
  logic [SW-1:0] st_lvl, st_prev, st_fall;
  strobe_sync #(.W(SW), .INIT(1'b1)) u_strobes (
    .clk(clk), .rst_n(rst_n), .in_raw({commit_n, ld_n}),
    .lvl(st_lvl), .prev(st_prev)
  );
  assign st_fall = st_prev & ~st_lvl;

  logic mode_lvl, mode_prev, mode_chg;
  strobe_sync #(.W(1), .INIT(1'b0)) u_mode (
    .clk(clk), .rst_n(rst_n), .in_raw(mode_sync),
    .lvl(mode_lvl), .prev(mode_prev)
  );
  assign mode_chg = mode_lvl ^ mode_prev;

  logic [NCH-1:0]    loading;
  logic [NCH*FW-1:0] pend_freq;
  logic [NCH*PW-1:0] pend_phase;
  logic              any_loading;
  logic              commit_go;

  assign any_loading = |loading;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_loader #(
      .FW(FW), .PW(PW), .LOAD_CYC(LOAD_CYC), .DEF_FREQ(DEF_FREQ)
    ) u_ld (
      .clk(clk), .rst_n(rst_n), .clr(mode_chg), .en(mode_lvl),
      .go(st_fall[c]), .freq_in(freq_word), .phase_in(phase_word),
      .pend_freq(pend_freq[c*FW +: FW]), .pend_phase(pend_phase[c*PW +: PW]),
      .loading(loading[c]), .err(ld_err[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || mode_chg) begin
        act_freq[c*FW +: FW]  <= DEF_FREQ;
        act_phase[c*PW +: PW] <= '0;
      end else if (commit_go) begin
        act_freq[c*FW +: FW]  <= pend_freq[c*FW +: FW];
        act_phase[c*PW +: PW] <= pend_phase[c*PW +: PW];
      end
    end
  end

  commit_ctrl #(.APPLY_CYC(APPLY_CYC), .SETUP_CYC(SETUP_CYC)) u_cmt (
    .clk(clk), .rst_n(rst_n), .clr(mode_chg), .en(mode_lvl),
    .go(st_fall[NCH]), .any_loading(any_loading),
    .commit_go(commit_go), .busy(busy), .err(commit_err)
  );

  p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_go && !mode_chg) |=> ($stable(act_freq) && $stable(act_phase)));

  p_busy_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_go));

  p_mode_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (act_freq[FW-1:0] == DEF_FREQ && act_phase[PW-1:0] == '0
                  && ld_err == '0 && !commit_err));

  p_indep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_lvl && !mode_chg) |=> (!$rose(busy) && $stable(act_freq)));
endmodule

// File: tb/sync_phase_loader_bench.sv
`timescale 1ns/1ps
module sync_phase_loader_bench;
  localparam int NCH = 9;
  localparam logic [47:0] DEF = 48'd10_000_000_000_000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mode_sync = 1'b1;
  logic [47:0]       freq_word = '0;
  logic [13:0]       phase_word = '0;
  logic [NCH-1:0]    ld_n = '1;
  logic              commit_n = 1'b1;
  logic              busy;
  logic [NCH*48-1:0] act_freq;
  logic [NCH*14-1:0] act_phase;
  logic [NCH-1:0]    ld_err;
  logic              commit_err;

  int checks = 0;
  int failures = 0;
  logic [47:0] ef [NCH];
  logic [13:0] ep [NCH];
  logic [47:0] pf [NCH];
  logic [13:0] pq [NCH];

  always #2.5 clk = ~clk;

  sync_phase_loader u_sync_phase_loader (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .freq_word(freq_word),
    .phase_word(phase_word), .ld_n(ld_n), .commit_n(commit_n), .busy(busy),
    .act_freq(act_freq), .act_phase(act_phase), .ld_err(ld_err),
    .commit_err(commit_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic set_defaults();
    for (int c = 0; c < NCH; c++) begin
      ef[c] = DEF; ep[c] = '0; pf[c] = DEF; pq[c] = '0;
    end
  endtask

  task automatic check_act(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk(act_freq[c*48 +: 48] == ef[c], req, $sformatf("freq ch%0d", c),
          64'(act_freq[c*48 +: 48]), 64'(ef[c]));
      chk(act_phase[c*14 +: 14] == ep[c], req, $sformatf("phase ch%0d", c),
          64'(act_phase[c*14 +: 14]), 64'(ep[c]));
    end
  endtask

  task automatic strobe(input int ch);
    @(negedge clk); ld_n[ch] = 1'b0;
    repeat (2) @(negedge clk);
    ld_n[ch] = 1'b1;
  endtask

  // R2, R3: one load; busy must stay low for the whole load and setup window.
  task automatic load_ch(input int ch, input logic [47:0] f, input logic [13:0] p);
    int hi = 0;
    freq_word = f; phase_word = p;
    strobe(ch);
    pf[ch] = f; pq[ch] = p;
    repeat (100) begin
      @(negedge clk);
      if (busy) hi++;
    end
    chk(hi == 0, "R3", "busy cycles during load", 64'(hi), 64'd0);
  endtask

  // R4: accepted commit; outputs due on the third rising edge, busy lasts 34 cycles.
  task automatic commit_ok(input string req);
    int n = 1;
    @(negedge clk); commit_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin ef[c] = pf[c]; ep[c] = pq[c]; end
    chk(busy == 1'b1, "R4", "busy at commit edge", 64'(busy), 64'd1);
    check_act(req);
    commit_n = 1'b1;
    while (busy && n < 100) begin
      @(posedge clk); #1;
      if (busy) n++;
    end
    chk(n == 34, "R4", "busy length", 64'(n), 64'd34);
  endtask

  // R6, R8: commit that must be dropped.
  task automatic commit_bad(input string req);
    int hi = 0;
    @(negedge clk); commit_n = 1'b0;
    repeat (2) @(negedge clk);
    commit_n = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (busy) hi++;
    end
    chk(hi == 0, req, "busy after dropped commit", 64'(hi), 64'd0);
    check_act(req);
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk); mode_sync = v;
    repeat (8) @(negedge clk);
    set_defaults();
  endtask

  task automatic t_reset();
    repeat (10) @(negedge clk);
    check_act("R1");
    chk(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
    chk(ld_err == '0, "R1", "ld_err", 64'(ld_err), 64'd0);
    chk(commit_err == 1'b0, "R1", "commit_err", 64'(commit_err), 64'd0);
  endtask

  task automatic t_full_program();
    load_ch(0, 48'd25_000_000_000_000, 14'd0);
    for (int c = 1; c < NCH; c++)
      load_ch(c, 48'd25_000_000_000_000, 14'(c * 1000 + 7));
    check_act("R2");
    commit_ok("R4");
    chk(ld_err == '0, "R5", "ld_err after clean loads", 64'(ld_err), 64'd0);
  endtask

  task automatic t_double_strobe();
    freq_word = 48'd25_000_000_000_000; phase_word = 14'd111;
    strobe(2);
    pf[2] = freq_word; pq[2] = 14'd111;
    repeat (5) @(negedge clk);
    phase_word = 14'd222;
    strobe(2);
    repeat (100) @(negedge clk);
    chk(ld_err == 9'b0_0000_0100, "R5", "ld_err pattern", 64'(ld_err), 64'h4);
    commit_ok("R5");
    chk(act_phase[5*14 +: 14] == 14'd5007, "R10", "untouched ch5 phase",
        64'(act_phase[5*14 +: 14]), 64'd5007);
  endtask

  task automatic t_commit_during_load();
    freq_word = 48'd25_000_000_000_000; phase_word = 14'd3333;
    strobe(3);
    repeat (10) @(negedge clk);
    commit_bad("R6");
    chk(commit_err == 1'b1, "R6", "commit_err", 64'(commit_err), 64'd1);
    pf[3] = 48'd25_000_000_000_000; pq[3] = 14'd3333;
    repeat (100) @(negedge clk);
    commit_ok("R6");
  endtask

  task automatic t_no_range_check();
    load_ch(0, 48'hFFFF_FFFF_FFFF, 14'd0);
    commit_ok("R9");
  endtask

  task automatic t_mode_change();
    set_mode(1'b0);
    check_act("R7");
    chk(ld_err == '0, "R7", "ld_err cleared", 64'(ld_err), 64'd0);
    chk(commit_err == 1'b0, "R7", "commit_err cleared", 64'(commit_err), 64'd0);
    freq_word = 48'd1234; phase_word = 14'd55;
    strobe(1);
    repeat (100) @(negedge clk);
    commit_bad("R8");
    set_mode(1'b1);
    check_act("R7");
    commit_ok("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    set_defaults();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_program();
    t_double_strobe();
    t_commit_during_load();
    t_no_range_check();
    t_mode_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule